// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block is a periodic interval timer that forms either the shared system tick or a per-processor profiling tick. An external prescaler supplies a one-cycle tick enable once per microsecond. On each tick the internal count advances by one. When a tick arrives while the count equals a non-zero programmed limit, the count restarts at 1. On that same tick a level interrupt is raised, and it stays high until software acknowledges it.

Software reaches the timer through a small word-addressed register window. The acknowledge is a read of the limit register, so no extra write is needed to retire an interrupt. A second address aliases the limit. Writing through it changes the period without disturbing the count or a pending interrupt. Limit and count values are carried in bits 31:10 of the data word. The low ten bits are ignored on writes and read back as zero.

The access port is a single-cycle strobe interface with no back-pressure. Every strobed access completes in the cycle it is presented. Read data returns exactly one cycle later, qualified by `rd_valid`. The requester must therefore always be able to accept a read response in the cycle after its request.

Top module: `tick_timer`

## Requirements
- R1: After reset the limit, the count and `irq` are all zero, and reads of offsets 0x0 and 0x4 return zero.
- R2: In each cycle with `tick_en` high and no terminal event, the count advances by one. In cycles without `tick_en` it holds.
- R3: A tick that arrives while the count equals a non-zero limit reloads the count to 1 and sets `irq`. `irq` then stays high until a limit read (offset 0x0) or a limit write (offset 0x0) clears it.
- R4: A read of offset 0x0 returns the limit in bits 31:10, with bits 9:0 zero, and clears `irq`.
- R5: A write to offset 0x0 loads the limit from `bus_wdata[31:10]`, sets the count to 1 and clears `irq`.
- R6: A write to offset 0x8 loads the limit from `bus_wdata[31:10]` and leaves both the count and `irq` unchanged.
- R7: A read of offset 0x8 returns the limit in bits 31:10 and does not clear `irq`.
- R8: A read of offset 0x4 returns `irq` in bit 31, the low 21 bits of the count in bits 30:10, and zero in bits 9:0.
- R9: With a limit of zero no interrupt is raised, and the count keeps advancing on ticks.
- R10: A terminal tick in the same cycle as a limit read leaves `irq` set. A limit write in the same cycle as a terminal tick wins: `irq` is cleared and the count becomes 1.
- R11: Writes to offset 0x4 or to any unmapped offset change nothing. Reads of unmapped offsets return zero.
- R12: Every read strobe produces `rd_valid` for exactly one cycle, in the next cycle. `rd_data` is zero whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle microsecond tick from the prescaler |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset: 0x0 limit, 0x4 count, 0x8 limit without clear |
| bus_wdata | input | 32 | Write data; the field sits in bits 31:10 |
| rd_valid | output | 1 | Read response valid, one cycle after the read strobe |
| rd_data | output | 32 | Read response data |
| irq | output | 1 | Level interrupt, held until acknowledged |

## Verification
The bench aims at the collisions between software access and the counter.

A limit read coincides with a terminal tick. A design that let the acknowledge win would lose a whole period's interrupt. A limit write coincides with a terminal tick. A design that let the tick win would assert a stale interrupt with the old period.

The no-clear alias is driven while an interrupt is pending. A design that decoded it like the normal limit address would drop the interrupt or restart the count. The limit-zero case runs ticks through the point where an unguarded compare would fire.

The count read is checked for the flag in bit 31. A design that exposed the raw count MSB there would disagree as soon as `irq` and the count diverge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Position of the value field inside the data word.
  localparam int unsigned FIELD_LSB = 10;

  // Register window, byte offsets.
  localparam int unsigned OFS_LIMIT      = 0;
  localparam int unsigned OFS_COUNT      = 4;
  localparam int unsigned OFS_LIMIT_KEEP = 8;

  typedef struct packed {
    logic rd_any;       // any read strobe, mapped or not
    logic rd_limit;     // read of the acknowledging limit address
    logic rd_count;     // read of the count / flag word
    logic rd_keep;      // read of the non-acknowledging limit alias
    logic wr_limit;     // write that restarts and clears
    logic wr_keep;      // write that only changes the period
  } tt_access_t;

endpackage

// File: rtl/tt_decode.sv
module tt_decode
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output tt_access_t        acc
);

  logic hit_limit;
  logic hit_count;
  logic hit_keep;

  always_comb begin
    hit_limit = (bus_addr == ADDR_W'(OFS_LIMIT));
    hit_count = (bus_addr == ADDR_W'(OFS_COUNT));
    hit_keep  = (bus_addr == ADDR_W'(OFS_LIMIT_KEEP));

    acc          = '0;
    acc.rd_any   = bus_en && !bus_wr;
    acc.rd_limit = bus_en && !bus_wr && hit_limit;
    acc.rd_count = bus_en && !bus_wr && hit_count;
    acc.rd_keep  = bus_en && !bus_wr && hit_keep;
    acc.wr_limit = bus_en &&  bus_wr && hit_limit;
    acc.wr_keep  = bus_en &&  bus_wr && hit_keep;
  end

endmodule

// File: rtl/tt_limit.sv
module tt_limit #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  output logic [CNT_W-1:0] limit_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
    end else if (load) begin
      limit_q <= value;
    end
  end

endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             terminal,
  output logic [CNT_W-2:0] count_low
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // A zero limit never matches, so the period is off.
  always_comb begin
    terminal  = tick_en && (limit != '0) && (cnt_q == limit);
    count_low = cnt_q[CNT_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= ONE;
    end else if (terminal) begin
      cnt_q <= ONE;
    end else if (tick_en) begin
      cnt_q <= cnt_q + ONE;
    end
  end

endmodule

// File: rtl/tt_flag.sv
module tt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  input  logic clear,
  output logic flag_q
);

  // clear (limit write) beats set; set beats ack so no period is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (clear) begin
      flag_q <= 1'b0;
    end else if (set) begin
      flag_q <= 1'b1;
    end else if (ack) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter  int unsigned ADDR_W = 5,
  parameter  int unsigned CNT_W  = 22,
  localparam int unsigned DATA_W = CNT_W + FIELD_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam logic [FIELD_LSB-1:0] LOW_ZERO = '0;

  tt_access_t       acc;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-2:0] count_low;
  logic             terminal;
  logic [DATA_W-1:0] rd_next;
  logic             unused_wdata_low;

  assign unused_wdata_low = ^bus_wdata[FIELD_LSB-1:0];

  tt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .acc      (acc)
  );

  tt_limit #(.CNT_W(CNT_W)) u_limit (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (acc.wr_limit || acc.wr_keep),
    .value   (bus_wdata[DATA_W-1:FIELD_LSB]),
    .limit_q (limit_q)
  );

  tt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .restart   (acc.wr_limit),
    .limit     (limit_q),
    .terminal  (terminal),
    .count_low (count_low)
  );

  tt_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (terminal),
    .ack    (acc.rd_limit),
    .clear  (acc.wr_limit),
    .flag_q (irq)
  );

  always_comb begin
    rd_next = '0;
    if (acc.rd_limit || acc.rd_keep) begin
      rd_next = {limit_q, LOW_ZERO};
    end else if (acc.rd_count) begin
      rd_next = {irq, count_low, LOW_ZERO};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc.rd_any;
      rd_data  <= acc.rd_any ? rd_next : '0;
    end
  end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 22,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic [CNT_W-1:0]  limit_q
);

  logic lim_access;
  assign lim_access = bus_en && (bus_addr == '0);

  // R3: a raised interrupt holds unless the limit address is accessed
  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !lim_access |=> irq);

  // R3: the interrupt only rises on a tick
  assert_irq_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick_en));

  // R4: a limit read without a tick acknowledges
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_wr && (bus_addr == '0) && !tick_en |=> !irq);

  // R5: a limit write always clears
  assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_wr && (bus_addr == '0) |=> !irq);

  // R9: zero limit never raises the interrupt
  assert_zero_limit_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_q == '0) && !irq |=> !irq);

  // R12: read response timing
  assert_read_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_wr |=> rd_valid);

  assert_no_spurious_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_wr) |=> !rd_valid);

  assert_idle_data_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  // R8: low field bits read as zero
  assert_low_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[9:0] == '0));

endmodule

bind tick_timer tick_timer_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .bus_en   (bus_en),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .irq      (irq),
  .limit_q  (limit_q)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_lim = '0;
  logic [31:0] m_cnt = '0;
  logic        m_irq = 1'b0;
  logic        m_rv = 1'b0;
  logic [31:0] m_rd = '0;

  always #5 clk = ~clk;

  tick_timer u_tick_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .irq       (irq)
  );

  task automatic compare(input string req);
    checks++;
    if (irq !== m_irq || rd_valid !== m_rv || rd_data !== m_rd) begin
      errors++;
      $display("FAIL %s: actual irq=%0b rv=%0b rd=%h expected irq=%0b rv=%0b rd=%h",
               req, irq, rd_valid, rd_data, m_irq, m_rv, m_rd);
    end
  endtask

  // One clock: drive at negedge, model after posedge, compare at next negedge.
  task automatic step(input bit en, input bit wr, input logic [4:0] a,
                      input logic [31:0] wd, input bit tk, input string req);
    logic term, wl, wk, rl;
    bus_en = en; bus_wr = wr; bus_addr = a; bus_wdata = wd; tick_en = tk;
    @(posedge clk);
    m_rv = en && !wr;
    m_rd = '0;
    if (m_rv) begin
      case (a)
        5'h00, 5'h08: m_rd = m_lim << 10;
        5'h04:        m_rd = ({31'b0, m_irq} << 31) | ((m_cnt & 32'h001F_FFFF) << 10);
        default:      m_rd = '0;
      endcase
    end
    term = tk && (m_lim != 0) && (m_cnt == m_lim);
    wl = en && wr && (a == 5'h00);
    wk = en && wr && (a == 5'h08);
    rl = en && !wr && (a == 5'h00);
    if (wl)        m_cnt = 1;
    else if (term) m_cnt = 1;
    else if (tk)   m_cnt = (m_cnt + 1) & 32'h003F_FFFF;
    if (wl)        m_irq = 1'b0;
    else if (term) m_irq = 1'b1;
    else if (rl)   m_irq = 1'b0;
    if (wl || wk)  m_lim = wd >> 10;
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(input int n, input bit tk, input string req);
    for (int i = 0; i < n; i++) step(0, 0, 5'h00, 32'h0, tk, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    // R1: reads after reset
    step(1, 0, 5'h00, 0, 0, "R1 limit read");
    step(1, 0, 5'h04, 0, 0, "R1 count read");
    idle(1, 0, "R12 response drop");
    // R9 / R2: limit zero, ticks and gaps
    idle(5, 1, "R9 zero limit ticks");
    idle(3, 0, "R2 hold without tick");
    step(1, 0, 5'h04, 0, 0, "R2 count read");
    idle(1, 0, "R12 response drop");
    // R5: program period of 4
    step(1, 1, 5'h00, 32'd4 << 10, 0, "R5 limit write");
    step(1, 0, 5'h04, 0, 1, "R2 count advance");
    idle(2, 1, "R2 ticks");
    idle(1, 1, "R3 terminal tick");
    step(1, 0, 5'h04, 0, 0, "R8 count flag");
    idle(3, 1, "R3 irq holds");
    // R7: alias read keeps irq
    step(1, 0, 5'h08, 0, 0, "R7 alias read");
    // R6: alias write keeps irq and count
    step(1, 1, 5'h08, 32'd6 << 10 | 32'h3FF, 1, "R6 alias write");
    step(1, 0, 5'h04, 0, 0, "R6 count kept");
    // R4: acknowledge
    step(1, 0, 5'h00, 0, 0, "R4 limit read ack");
    idle(1, 0, "R4 irq low");
    // R11: writes to count and unmapped, unmapped read
    step(1, 1, 5'h04, 32'hFFFF_FC00, 0, "R11 count write");
    step(1, 1, 5'h1C, 32'hFFFF_FC00, 1, "R11 unmapped write");
    step(1, 0, 5'h1C, 0, 0, "R11 unmapped read");
    step(1, 0, 5'h04, 0, 0, "R11 count read back");
    step(1, 0, 5'h08, 0, 0, "R11 limit read back");
    idle(1, 0, "R12 response drop");
    // R10: ack collides with terminal
    step(1, 1, 5'h00, 32'd3 << 10, 0, "R10 setup");
    idle(2, 1, "R10 ticks");
    step(1, 0, 5'h00, 0, 1, "R10 ack vs terminal");
    idle(1, 0, "R10 irq kept");
    step(1, 0, 5'h00, 0, 0, "R10 ack");
    idle(2, 1, "R10 ticks");
    step(1, 1, 5'h00, 32'd5 << 10, 1, "R10 write vs terminal");
    step(1, 0, 5'h04, 0, 0, "R10 count restart");
    // R12: back-to-back reads
    step(1, 0, 5'h08, 0, 1, "R12 b2b read");
    step(1, 0, 5'h04, 0, 1, "R12 b2b read");
    idle(12, 1, "R3 second period");
    step(1, 0, 5'h04, 0, 0, "R8 count flag");
    idle(1, 0, "R12 response drop");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule